// File: doc/BRIEF.md
# PCI Address Trap Detector

This block monitors every PCI transaction and compares its address phase against two independently programmed trap windows. Each window has an I/O address and a memory address, each with a small mask. When a bus cycle of the right kind lands inside a window, the block raises a one-clock event for that window. Downstream logic can use the event to request a management or power interrupt, or to reload an idle timer. The block never needs to be the target of the transaction, and it drives nothing onto the bus.

Software programs the windows through four 32-bit configuration words on a simple synchronous write port with a combinational read port. The first word holds both I/O addresses. The next two words hold the memory addresses for channel 1 and channel 2. The last word holds all four masks. A mask bit set to one turns that address bit into a "don't care". Mask bits reach only the low eight bits of each compared slice. The address phase is captured on the clock edge where FRAME# is first seen low. The command nibble taken at that edge decides whether the I/O comparison or the memory comparison applies.

Top module: `pci_trap_detect`

## Requirements
- R1: After reset, all four configuration words read as zero and both `trap_evt` bits are low.
- R2: Word 0 (`cfg_addr`=0) holds the channel 1 I/O address in bits [15:0] and the channel 2 I/O address in bits [31:16]. Word 3 holds the masks: channel 1 I/O in [7:0], channel 2 I/O in [15:8], channel 1 memory in [23:16], and channel 2 memory in [31:24]. Both words read back exactly what was written.
- R3: Words 1 and 2 hold the channel 1 and channel 2 memory addresses in bits [31:10]. Bits [9:0] ignore writes and read as zero.
- R4: The address and command are sampled only on the first rising clock edge at which `frame_n` is low after being high. Holding `frame_n` low for further cycles does not sample again.
- R5: An I/O hit compares `ad[15:0]` with the channel's I/O address. Bits that are set in the channel's 8-bit I/O mask are ignored, and the mask reaches only bits [7:0]. Bits [15:8] must match exactly, and `ad[31:16]` plays no part.
- R6: A memory hit compares `ad[31:10]` with the channel's memory address. The 8-bit memory mask reaches only bits [17:10]. Bits [31:18] must match exactly, and `ad[9:0]` plays no part.
- R7: Command values (the value on `cbe_n`) 4'b0010 and 4'b0011 are I/O cycles and use only the I/O comparison. Values 4'b0110, 4'b0111, 4'b1100, 4'b1110 and 4'b1111 are memory cycles and use only the memory comparison. Every other value never produces an event.
- R8: Each hit gives a `trap_evt` pulse exactly one clock long, high in the cycle that follows the sampling edge.
- R9: The two channels are evaluated independently. `trap_evt[0]` belongs to channel 1 and `trap_evt[1]` to channel 2, and both may pulse in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_n | input | 1 | Bus FRAME#, active low |
| ad | input | 32 | Bus address/data lines |
| cbe_n | input | 4 | Bus command / byte enables |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration word select |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data (combinational) |
| trap_evt | output | 2 | Per-channel trap pulse |

## Verification
There is one register between the bus and the event. An address phase driven before the sampling edge must therefore show its event in the next cycle and nowhere else. The bench drives every input on the falling edge. It checks `trap_evt` at the falling edge just after the sampling edge, and then again one cycle later to confirm the pulse has ended. A configuration write takes effect at the rising edge after the strobe, and reads are combinational. For that reason, readbacks are checked a short delay after the select is changed on a falling edge.

// File: rtl/pat_pkg.sv
package pat_pkg;

    localparam int ADDR_W   = 32;
    localparam int CMD_W    = 4;
    localparam int NUM_CH   = 2;
    localparam int MASK_W   = 8;
    localparam int IO_W     = 16;
    localparam int MEM_LSB  = 10;
    localparam int MEM_W    = ADDR_W - MEM_LSB;
    localparam int CFG_AW   = 2;

    localparam logic [CFG_AW-1:0] WORD_IO   = 2'd0;
    localparam logic [CFG_AW-1:0] WORD_MEM0 = 2'd1;
    localparam logic [CFG_AW-1:0] WORD_MASK = 2'd3;

    typedef enum logic [1:0] {
        CYC_NONE = 2'd0,
        CYC_IO   = 2'd1,
        CYC_MEM  = 2'd2
    } cyc_kind_e;

    typedef struct packed {
        logic              valid;
        cyc_kind_e         kind;
        logic [ADDR_W-1:0] addr;
    } addr_phase_t;

    typedef struct packed {
        logic [IO_W-1:0]   io_addr;
        logic [MEM_W-1:0]  mem_addr;
        logic [MASK_W-1:0] io_mask;
        logic [MASK_W-1:0] mem_mask;
    } chan_cfg_t;

    function automatic cyc_kind_e classify(input logic [CMD_W-1:0] cmd);
        case (cmd)
            4'b0010, 4'b0011:                            classify = CYC_IO;
            4'b0110, 4'b0111, 4'b1100, 4'b1110, 4'b1111: classify = CYC_MEM;
            default:                                     classify = CYC_NONE;
        endcase
    endfunction

    // Both operands are widened to ADDR_W. The mask only reaches the low MASK_W bits.
    function automatic logic masked_hit(input logic [ADDR_W-1:0] bus_val,
                                        input logic [ADDR_W-1:0] prog_val,
                                        input logic [MASK_W-1:0] mask);
        logic [ADDR_W-1:0] m;
        m = {{(ADDR_W-MASK_W){1'b0}}, mask};
        masked_hit = ((bus_val | m) == (prog_val | m));
    endfunction

endpackage

// File: rtl/pat_phase_capture.sv
module pat_phase_capture
    import pat_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                frame_n,
    input  logic [ADDR_W-1:0]   ad,
    input  logic [CMD_W-1:0]    cbe_n,
    output addr_phase_t         phase
);

    logic frame_q;
    logic start;

    assign start = frame_q & ~frame_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= 1'b1;
            phase   <= '0;
        end else begin
            frame_q     <= frame_n;
            phase.valid <= start;
            if (start) begin
                phase.kind <= classify(cbe_n);
                phase.addr <= ad;
            end
        end
    end

endmodule

// File: rtl/pat_cfg_regs.sv
module pat_cfg_regs
    import pat_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_wr,
    input  logic [CFG_AW-1:0]        cfg_addr,
    input  logic [ADDR_W-1:0]        cfg_wdata,
    output logic [ADDR_W-1:0]        cfg_rdata,
    output chan_cfg_t [NUM_CH-1:0]   cfg
);

    logic [ADDR_W-1:0] io_word;
    logic [ADDR_W-1:0] mask_word;
    logic [MEM_W-1:0]  mem_q [NUM_CH];

    always_ff @(posedge clk) begin
        if (rst) begin
            io_word   <= '0;
            mask_word <= '0;
            for (int c = 0; c < NUM_CH; c++) mem_q[c] <= '0;
        end else if (cfg_wr) begin
            if (cfg_addr == WORD_IO)   io_word   <= cfg_wdata;
            if (cfg_addr == WORD_MASK) mask_word <= cfg_wdata;
            for (int c = 0; c < NUM_CH; c++) begin
                if (cfg_addr == WORD_MEM0 + CFG_AW'(c))
                    mem_q[c] <= cfg_wdata[ADDR_W-1:MEM_LSB];
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr == WORD_IO)   cfg_rdata = io_word;
        if (cfg_addr == WORD_MASK) cfg_rdata = mask_word;
        for (int c = 0; c < NUM_CH; c++) begin
            if (cfg_addr == WORD_MEM0 + CFG_AW'(c))
                cfg_rdata = {mem_q[c], {MEM_LSB{1'b0}}};
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_unpack
        assign cfg[c].io_addr  = io_word[IO_W*c +: IO_W];
        assign cfg[c].io_mask  = mask_word[MASK_W*c +: MASK_W];
        assign cfg[c].mem_mask = mask_word[MASK_W*(NUM_CH+c) +: MASK_W];
        assign cfg[c].mem_addr = mem_q[c];
    end

endmodule

// File: rtl/pat_chan_match.sv
module pat_chan_match
    import pat_pkg::*;
(
    input  addr_phase_t phase,
    input  chan_cfg_t   cfg,
    output logic        hit
);

    logic io_hit;
    logic mem_hit;

    always_comb begin
        io_hit  = (phase.kind == CYC_IO) &&
                  masked_hit({{(ADDR_W-IO_W){1'b0}}, phase.addr[IO_W-1:0]},
                             {{(ADDR_W-IO_W){1'b0}}, cfg.io_addr},
                             cfg.io_mask);
        mem_hit = (phase.kind == CYC_MEM) &&
                  masked_hit({{MEM_LSB{1'b0}}, phase.addr[ADDR_W-1:MEM_LSB]},
                             {{MEM_LSB{1'b0}}, cfg.mem_addr},
                             cfg.mem_mask);
        hit     = phase.valid & (io_hit | mem_hit);
    end

endmodule

// File: rtl/pci_trap_detect.sv
module pci_trap_detect
    import pat_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                frame_n,
    input  logic [ADDR_W-1:0]   ad,
    input  logic [CMD_W-1:0]    cbe_n,
    input  logic                cfg_wr,
    input  logic [CFG_AW-1:0]   cfg_addr,
    input  logic [ADDR_W-1:0]   cfg_wdata,
    output logic [ADDR_W-1:0]   cfg_rdata,
    output logic [NUM_CH-1:0]   trap_evt
);

    addr_phase_t             phase;
    chan_cfg_t [NUM_CH-1:0]  cfg;

    pat_phase_capture u_cap (
        .clk     (clk),
        .rst     (rst),
        .frame_n (frame_n),
        .ad      (ad),
        .cbe_n   (cbe_n),
        .phase   (phase)
    );

    pat_cfg_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .cfg       (cfg)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pat_chan_match u_match (
            .phase (phase),
            .cfg   (cfg[c]),
            .hit   (trap_evt[c])
        );
    end

endmodule

// File: rtl/pat_checker.sv
module pat_checker
    import pat_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                frame_n,
    input  logic [ADDR_W-1:0]   ad,
    input  logic [CMD_W-1:0]    cbe_n,
    input  logic                cfg_wr,
    input  logic [CFG_AW-1:0]   cfg_addr,
    input  logic [ADDR_W-1:0]   cfg_wdata,
    input  logic [ADDR_W-1:0]   cfg_rdata,
    input  logic [NUM_CH-1:0]   trap_evt
);

    // R8: a pulse never lasts longer than one cycle
    p_evt_single_r8: assert property (@(posedge clk) disable iff (rst)
        (trap_evt != '0) |=> (trap_evt == '0));

    // R4: an event only follows a cycle in which frame_n was low
    p_evt_after_frame_r4: assert property (@(posedge clk) disable iff (rst)
        (trap_evt != '0) |-> ($past(frame_n) == 1'b0));

    // R7: commands that are neither I/O nor memory stay silent
    p_illegal_cmd_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        $past(!frame_n && (classify(cbe_n) == CYC_NONE)) |-> (trap_evt == '0));

    // R2: the I/O address word reads back what was written
    p_io_word_write_r2: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_addr == WORD_IO) |=>
        (cfg_addr != WORD_IO || cfg_rdata == $past(cfg_wdata)));

    // R3: the memory word keeps only bits [31:10]
    p_mem_reserved_r3: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_addr == WORD_MEM0) |=>
        (cfg_addr != WORD_MEM0 ||
         cfg_rdata == {$past(cfg_wdata[ADDR_W-1:MEM_LSB]), {MEM_LSB{1'b0}}}));

endmodule

bind pci_trap_detect pat_checker u_chk (.*);

// File: tb/sim_pci_trap_detect.sv
`timescale 1ns/1ps
module sim_pci_trap_detect;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_n = 1'b1;
    logic [31:0] ad = '0;
    logic [3:0]  cbe_n = 4'hF;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [1:0]  trap_evt;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    pci_trap_detect u0 (.*);

    // Each vector: address, command, expected {ch2,ch1} event
    localparam int NV = 16;
    localparam logic [37:0] VEC [NV] = '{
        {32'h0000_03F8, 4'b0010, 2'b01},  // R5 ch1 exact I/O
        {32'h0000_03FF, 4'b0011, 2'b01},  // R5 masked low bits
        {32'h0000_03F0, 4'b0010, 2'b00},  // R5 bit3 outside mask
        {32'h0000_1230, 4'b0011, 2'b10},  // R9 ch2 I/O
        {32'h0000_1231, 4'b0010, 2'b00},  // R5 ch2 mask zero
        {32'h0001_03F8, 4'b0010, 2'b01},  // R5 ad[31:16] ignored
        {32'h0000_13F8, 4'b0010, 2'b00},  // R5 upper I/O bits exact
        {32'h0000_03F8, 4'b0110, 2'b00},  // R7 I/O addr on mem cmd
        {32'hFEDC_0000, 4'b0110, 2'b01},  // R6 ch1 mem
        {32'hFEDC_0FFF, 4'b0111, 2'b01},  // R6 mask bits 11:10, 9:0 ignored
        {32'hFEDC_1000, 4'b1100, 2'b00},  // R6 bit12 not masked
        {32'h8003_FC00, 4'b1110, 2'b10},  // R6 ch2 17:10 masked
        {32'h8004_0000, 4'b1111, 2'b00},  // R6 bit18 exact
        {32'hFEDC_0000, 4'b0000, 2'b00},  // R7 illegal cmd
        {32'hFEDC_0000, 4'b1010, 2'b00},  // R7 illegal cmd
        {32'h0000_03F8, 4'b1011, 2'b00}   // R7 illegal cmd
    };

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_check(input logic [1:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        cfg_addr = a;
        #1;
        chk(cfg_rdata, exp, req);
    endtask

    // Address phase before an edge; event due one cycle later; gone the cycle after
    task automatic bus_cycle(input logic [31:0] a, input logic [3:0] c,
                             input logic [1:0] exp, input string req);
        @(negedge clk);
        frame_n = 1'b0; ad = a; cbe_n = c;
        @(negedge clk);
        chk({30'b0, trap_evt}, {30'b0, exp}, req);
        frame_n = 1'b1; ad = '0; cbe_n = 4'hF;
        @(negedge clk);
        chk({30'b0, trap_evt}, 32'h0, "R8 pulse end");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog R8 actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk({30'b0, trap_evt}, 32'h0, "R1 evt");
        for (int w = 0; w < 4; w++) cfg_check(2'(w), 32'h0, "R1 word");

        // R2 / R3 programming and readback
        cfg_write(2'd0, 32'h1230_03F8);
        cfg_write(2'd3, 32'hFF03_0007);
        cfg_write(2'd1, 32'hFEDC_03FF);
        cfg_write(2'd2, 32'h8000_0155);
        cfg_check(2'd0, 32'h1230_03F8, "R2 io word");
        cfg_check(2'd3, 32'hFF03_0007, "R2 mask word");
        cfg_check(2'd1, 32'hFEDC_0000, "R3 mem1 reserved");
        cfg_check(2'd2, 32'h8000_0000, "R3 mem2 reserved");

        // Table walk
        for (int i = 0; i < NV; i++)
            bus_cycle(VEC[i][37:6], VEC[i][5:2], VEC[i][1:0], "R5/R6/R7 vector");

        // R4: frame_n held low samples once only
        @(negedge clk);
        frame_n = 1'b0; ad = 32'h0000_03F8; cbe_n = 4'b0010;
        @(negedge clk);
        chk({30'b0, trap_evt}, 32'h1, "R4 first sample");
        @(negedge clk);
        chk({30'b0, trap_evt}, 32'h0, "R4 held low no resample");
        @(negedge clk);
        chk({30'b0, trap_evt}, 32'h0, "R4 held low no resample");
        frame_n = 1'b1;
        @(negedge clk);
        chk({30'b0, trap_evt}, 32'h0, "R4 after release");

        // R9 both channels in one cycle
        cfg_write(2'd0, 32'h03F8_03F8);
        bus_cycle(32'h0000_03F8, 4'b0011, 2'b11, "R9 both channels");
        bus_cycle(32'h0000_03FC, 4'b0011, 2'b01, "R9 ch2 exact, ch1 masked");

        // R8 back-to-back transactions each pulse
        bus_cycle(32'hFEDC_0400, 4'b0110, 2'b01, "R8 repeat pulse");

        // R1 reset clears configuration
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        cfg_check(2'd0, 32'h0, "R1 io after reset");
        cfg_check(2'd3, 32'h0, "R1 mask after reset");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule